// File: doc/BRIEF.md
# Display and Keypad Control Port with Memory-Mode Latch

This block is one 16-bit memory-mapped I/O word at address 0xFF00. A write to that address stores a control word. The word drives an 8-bit character-display data bus and the display's register-select, direction and enable lines. It also drives a status LED, a 3-bit keypad row number and one spare output. The stored row number is decoded into eight active-low row strobes for a scanned keypad matrix.

Reading the same address returns a different layout. It gives the display's data bus as seen from outside, five keypad column inputs, two push-button inputs and one spare input.

The port also feeds a second register: a 4-bit memory-mode latch that selects the system's bank arrangement. Firmware loads it by writing the port with the display enable and register-select bits both low and the top bit high. The low data bits then give the new mode, and the display sees no enable pulse during that write. Writes take effect on the clock edge that samples the strobe. Reads are combinational.

Top module: `kbd_lcd_port`

## Requirements
- R1: After reset, every output-register field is 0. So `lcd_db_out`, `lcd_rs`, `lcd_rw`, `lcd_en`, `led` and `ext_out` are 0, the row number is 0 (`row_sel_n` = 8'hFE), and `bank_mode` is 4'h0.
- R2: A write (`bus_wr`=1) to address 0xFF00 updates the outputs on the next clock edge, using this field map: bits 7:0 to `lcd_db_out`, bit 8 to `led`, bit 9 to `lcd_rs`, bit 10 to `lcd_rw`, bit 11 to `lcd_en`, bits 14:12 to the row number and bit 15 to `ext_out`.
- R3: A write to any other address leaves every output unchanged.
- R4: `row_sel_n[k]` is 0 exactly when the stored row number equals k. Exactly one of the eight lines is low at all times.
- R5: A write to 0xFF00 with bit 11=0, bit 9=0 and bit 15=1 loads data bits 3:0 into `bank_mode` on the next edge. Bits 5:4 have no effect on `bank_mode`.
- R6: `bank_mode` keeps its value on every other write, whether to the port or elsewhere, and when no write occurs.
- R7: While `bus_rd`=1 at 0xFF00, `rd_data` returns this layout in the same cycle: bits 7:0 from `lcd_db_in`, bits 12:8 from `kb_col[4:0]`, bits 14:13 from `btn[1:0]` and bit 15 from `ext_in`. `rd_en` is 1.
- R8: When `bus_rd`=0 or the address is not 0xFF00, `rd_en` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 16 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, zero when not selected |
| rd_en | output | 1 | High while this port drives read data |
| lcd_db_in | input | 8 | Display data bus read-back |
| kb_col | input | 5 | Keypad column inputs |
| btn | input | 2 | Extra push-button inputs |
| ext_in | input | 1 | Spare input |
| lcd_db_out | output | 8 | Display data bus drive value |
| lcd_rs | output | 1 | Display register select (0 command, 1 data) |
| lcd_rw | output | 1 | Display direction (0 write, 1 read) |
| lcd_en | output | 1 | Display enable |
| led | output | 1 | Status LED |
| ext_out | output | 1 | Spare output |
| row_sel_n | output | 8 | Active-low keypad row strobes |
| bank_mode | output | 4 | Memory-mode latch |

## Verification
Register outputs and `bank_mode` change one clock edge after a write strobe is sampled, and `row_sel_n` follows the stored row number with no further register. The bench drives each write on a falling edge and removes it on the next falling edge, then compares all outputs once the single rising edge between them has passed. The read path has no register, so read checks are made 1 ns after the inputs change, within the same cycle. The bench tracks a model of the stored word and the mode latch. It updates the model from the field rules only on writes to 0xFF00.

// File: rtl/kbd_lcd_pkg.sv
package kbd_lcd_pkg;
   localparam int LCD_W  = 8;
   localparam int KB_W   = 5;
   localparam int BTN_W  = 2;
   localparam int ROW_AW = 3;
   localparam int ROWS   = 1 << ROW_AW;
   localparam int WORD_W = 16;

   // Write-side word, MSB first (bit 15 down to bit 0)
   typedef struct packed {
      logic              xout;
      logic [ROW_AW-1:0] row;
      logic              en;
      logic              rw;
      logic              rs;
      logic              led;
      logic [LCD_W-1:0]  lcd;
   } wr_word_t;

   // Read-side word, MSB first
   typedef struct packed {
      logic             xin;
      logic [BTN_W-1:0] btn;
      logic [KB_W-1:0]  kb;
      logic [LCD_W-1:0] lcd;
   } rd_word_t;
endpackage

// File: rtl/port_decode.sv
module port_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] PORT_ADDR = 16'hFF00
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_hit,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] MATCH = PORT_ADDR[ADDR_W-1:0];

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
         $error("port_decode: ADDR_W out of range");
      end
   endgenerate

   logic match;
   assign match  = (addr == MATCH);
   assign wr_hit = wr & match;
   assign rd_hit = rd & match;
endmodule

// File: rtl/port_ctrl_reg.sv
module port_ctrl_reg
   import kbd_lcd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_hit,
   input  wr_word_t wdata,
   output wr_word_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_hit) q <= wdata;
   end

   // R2
   reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (q == $past(wdata)));
   // R3
   reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(q));
endmodule

// File: rtl/row_decode.sv
module row_decode #(
   parameter int AW = 3,
   localparam int N = 1 << AW
) (
   input  logic [AW-1:0] row,
   output logic [N-1:0]  sel_n
);
   generate
      if (AW < 1 || AW > 6) begin : g_bad_aw
         $error("row_decode: AW out of range");
      end
      for (genvar k = 0; k < N; k++) begin : g_line
         assign sel_n[k] = (row != AW'(k));
      end
   endgenerate

   // R4
   always_comb begin
      if (!$isunknown(row)) begin
         row_onehot_chk: assert ($countones(~sel_n) == 1 && sel_n[row] == 1'b0);
      end
   end
endmodule

// File: rtl/bank_latch.sv
module bank_latch
   import kbd_lcd_pkg::*;
#(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  wr_word_t          wdata,
   output logic [BANK_W-1:0] bank
);
   generate
      if (BANK_W < 1 || BANK_W > LCD_W) begin : g_bad_bw
         $error("bank_latch: BANK_W must fit in the display data field");
      end
   endgenerate

   // Load qualifier: display disabled, command select, spare bit high
   logic load;
   assign load = wr_hit & ~wdata.en & ~wdata.rs & wdata.xout;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bank <= '0;
      else if (load) bank <= wdata.lcd[BANK_W-1:0];
   end

   // R5
   bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wdata.en && !wdata.rs && wdata.xout)
         |=> (bank == $past(wdata.lcd[BANK_W-1:0])));
   // R6
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && !wdata.en && !wdata.rs && wdata.xout) |=> $stable(bank));
endmodule

// File: rtl/read_mux.sv
module read_mux
   import kbd_lcd_pkg::*;
(
   input  logic               rd_hit,
   input  logic [LCD_W-1:0]   lcd_in,
   input  logic [KB_W-1:0]    kb,
   input  logic [BTN_W-1:0]   btn,
   input  logic               xin,
   output logic [WORD_W-1:0]  rd_data,
   output logic               rd_en
);
   rd_word_t word;

   always_comb begin
      word.lcd = lcd_in;
      word.kb  = kb;
      word.btn = btn;
      word.xin = xin;
   end

   assign rd_en   = rd_hit;
   assign rd_data = rd_hit ? word : '0;
endmodule

// File: rtl/kbd_lcd_port.sv
module kbd_lcd_port
   import kbd_lcd_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] PORT_ADDR = 16'hFF00,
   parameter int          BANK_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [15:0]       rd_data,
   output logic              rd_en,
   input  logic [7:0]        lcd_db_in,
   input  logic [4:0]        kb_col,
   input  logic [1:0]        btn,
   input  logic              ext_in,
   output logic [7:0]        lcd_db_out,
   output logic              lcd_rs,
   output logic              lcd_rw,
   output logic              lcd_en,
   output logic              led,
   output logic              ext_out,
   output logic [7:0]        row_sel_n,
   output logic [BANK_W-1:0] bank_mode
);
   generate
      if ($bits(wr_word_t) != WORD_W || $bits(rd_word_t) != WORD_W) begin : g_bad_word
         $error("kbd_lcd_port: word layouts must be 16 bits");
      end
      if (ROWS != 8 || LCD_W != 8 || KB_W != 5 || BTN_W != 2) begin : g_bad_pins
         $error("kbd_lcd_port: port widths disagree with package");
      end
   endgenerate

   logic     wr_hit, rd_hit;
   wr_word_t wword, ctrl_q;

   assign wword = wr_word_t'(bus_wdata);

   port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wr_hit(wr_hit), .rd_hit(rd_hit));

   port_ctrl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wword), .q(ctrl_q));

   row_decode #(.AW(ROW_AW)) u_row (.row(ctrl_q.row), .sel_n(row_sel_n));

   bank_latch #(.BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(wword), .bank(bank_mode));

   read_mux u_rd (
      .rd_hit(rd_hit), .lcd_in(lcd_db_in), .kb(kb_col), .btn(btn), .xin(ext_in),
      .rd_data(rd_data), .rd_en(rd_en));

   assign lcd_db_out = ctrl_q.lcd;
   assign lcd_rs     = ctrl_q.rs;
   assign lcd_rw     = ctrl_q.rw;
   assign lcd_en     = ctrl_q.en;
   assign led        = ctrl_q.led;
   assign ext_out    = ctrl_q.xout;

   // R8
   rd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (bus_rd && bus_addr == PORT_ADDR[ADDR_W-1:0]));
   // R8
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));
   // R7
   rd_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_data == {ext_in, btn, kb_col, lcd_db_in}));
endmodule

// File: tb/test_kbd_lcd_port.sv
module test_kbd_lcd_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] rd_data;
   logic        rd_en;
   logic [7:0]  lcd_db_in = '0;
   logic [4:0]  kb_col = '0;
   logic [1:0]  btn = '0;
   logic        ext_in = 1'b0;
   logic [7:0]  lcd_db_out, row_sel_n;
   logic        lcd_rs, lcd_rw, lcd_en, led, ext_out;
   logic [3:0]  bank_mode;

   int checks = 0, failures = 0, cycles = 0;
   logic [15:0] exp_word = '0;
   logic [3:0]  exp_bank = '0;

   always #4 clk = ~clk;

   kbd_lcd_port i_kbd_lcd_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data), .rd_en(rd_en),
      .lcd_db_in(lcd_db_in), .kb_col(kb_col), .btn(btn), .ext_in(ext_in),
      .lcd_db_out(lcd_db_out), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
      .led(led), .ext_out(ext_out), .row_sel_n(row_sel_n), .bank_mode(bank_mode));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_outputs(input string tag);
      logic [7:0] exp_rows;
      exp_rows = ~(8'h01 << exp_word[14:12]);
      chk({tag, " outputs"}, {ext_out, 3'b000, lcd_en, lcd_rw, lcd_rs, led, lcd_db_out},
          {exp_word[15], 3'b000, exp_word[11:0]});
      chk("R4 row strobes", {24'h0, row_sel_n}, {24'h0, exp_rows});
      chk("R5/R6 bank_mode", {28'h0, bank_mode}, {28'h0, exp_bank});
   endtask

   task automatic do_write(input logic [15:0] a, input logic [15:0] d, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 16'hFF00) begin
         exp_word = d;
         if (!d[11] && !d[9] && d[15]) exp_bank = d[3:0];
      end
      chk_outputs(tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_outputs("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_outputs("R1 after release");

      // R2 R4 R5 R6: every control byte combined with varied low byte
      for (int i = 0; i < 256; i++) begin
         do_write(16'hFF00, {i[7:0], 8'(i * 37 + 11)}, "R2 sweep");
      end

      // R3 R6: writes elsewhere ignored
      for (int i = 0; i < 64; i++) begin
         logic [15:0] a;
         a = 16'(i * 1031) ^ 16'h5A5A;
         if (a == 16'hFF00) a = 16'hFF01;
         do_write(a, 16'h8000 | 16'(i * 97), "R3 other address");
      end
      do_write(16'hFF01, 16'h8005, "R3 neighbour address");
      do_write(16'h7F00, 16'h800A, "R3 neighbour address");

      // R5: every mode value with bits 5:4 varied
      for (int v = 0; v < 16; v++) begin
         do_write(16'hFF00, 16'h8000 | 16'((v % 4) << 4) | 16'(v), "R5 bank load");
      end
      // R6: qualifier bits not satisfied, bank must hold
      do_write(16'hFF00, 16'h8003, "R5 set mode 3");
      do_write(16'hFF00, 16'h880C, "R6 enable high");
      do_write(16'hFF00, 16'h820C, "R6 select high");
      do_write(16'hFF00, 16'h000C, "R6 spare low");

      // R7: read layout sweep
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         bus_addr = 16'hFF00; bus_rd = 1'b1;
         kb_col = i[4:0]; btn = i[6:5]; ext_in = i[7];
         lcd_db_in = 8'(i * 53 + 7);
         #1;
         chk("R7 rd_data", {16'h0, rd_data}, {16'h0, ext_in, btn, kb_col, lcd_db_in});
         chk("R7 rd_en", {31'h0, rd_en}, 32'h1);
      end
      // R8: other addresses and idle strobe
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         bus_addr = 16'hFF00 ^ 16'(1 << (i % 16));
         bus_rd = (i < 16);
         if (i >= 16) bus_addr = 16'hFF00;
         #1;
         chk("R8 rd_en", {31'h0, rd_en}, 32'h0);
         chk("R8 rd_data", {16'h0, rd_data}, 32'h0);
      end
      @(negedge clk);
      bus_rd = 1'b0;

      // R1: reset mid-run clears everything
      do_write(16'hFF00, 16'hF1FF, "R2 pre-reset");
      do_write(16'hFF00, 16'h8009, "R5 pre-reset");
      rst_n = 1'b0;
      exp_word = '0; exp_bank = '0;
      #1;
      chk_outputs("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_outputs("R1 after second release");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule